// File: doc/BRIEF.md
# Power-Cutback Frame Keyer

This block sends a short 20-bit control frame to the far end of a line during start-up. The frame carries a requested transmit power cutback and a flag that tells whether the last frame received failed its check. The line signal itself is an ordinary scrambled two-level stream produced elsewhere. This block only chooses its amplitude. A frame bit of one is sent at full power, and a frame bit of zero is sent with 7 dB of cutback. Each bit is held for a fixed number of 1 ms ticks, 10 by default.

A controller loads a 4-bit cutback value (0 to 15 dB in 1 dB steps) and the error flag, then pulses `start`. The block captures both inputs and appends a 4-bit CRC. It then walks the frame from the first bit to the last, driving `pwr_full`. `busy` stays high for the whole frame. `done` pulses once when the frame is finished.

The controller is a three-state machine:
- **IDLE** waits for a start request.
- **SEND** holds the current bit and shifts to the next one at each bit-period end.
- **DONE** lasts one cycle.

Its transitions are:
- **IDLE→SEND** on `start`.
- **SEND→SEND** at a bit-period end that is not the last one.
- **SEND→DONE** at the end of the twentieth period.
- **DONE→IDLE** unconditionally.

Top module: `pcbf_tx`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `pwr_full` is 1. Outside state SEND, `pwr_full` is always 1.
- R2: A `start` pulse while the block is idle is accepted at that clock edge. In the following cycle `busy` is 1 and the first frame bit is on `pwr_full`.
- R3: The frame is sent in this order:
  - the start pattern 1 then 0;
  - the error flag;
  - the four cutback bits, most significant first;
  - nine zero bits;
  - the four CRC bits, most significant first.
- R4: `pwr_full` is 1 while a frame bit of 1 is sent (0 dB cutback) and 0 while a frame bit of 0 is sent (7 dB cutback).
- R5: Each bit is held for exactly TICKS_PER_BIT cycles with `ms_tick` high. Cycles without a tick never advance the frame, and ticks while idle have no effect.
- R6: The CRC uses generator x^4+x+1 with an initial value of zero. It is computed most significant bit first over the 14 bits from the error flag to the last zero bit.
- R7: A `start` pulse while `busy` is 1 is ignored. The frame in progress continues unchanged.
- R8: `done` is 1 for exactly one cycle, in the cycle after the tick that ends the twentieth bit period. During that cycle `busy` is still 1, and `busy` is 0 from the next cycle on.
- R9: `cutback` and `crc_err_in` are sampled only at an accepted start. Changes to them during a frame do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send one frame |
| ms_tick | input | 1 | One-cycle pulse every 1 ms |
| cutback | input | 4 | Requested far-end cutback in dB |
| crc_err_in | input | 1 | Last received frame failed its CRC |
| pwr_full | output | 1 | 1 = full power, 0 = 7 dB cutback |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame-complete pulse |

## Verification
Directed frames with cutback 0 and 15, with and without the error flag, separate the fixed start and zero fields from the data-dependent CRC bits. Random cutback values with a fixed seed expose bit-order and CRC-polynomial errors, because every CRC nibble differs. Random gaps between ticks, extra ticks while idle, and a check one tick before each period ends tell tick counting apart from cycle counting. A start pulse with new inputs mid-frame, together with input changes during a frame, shows whether a frame can be restarted or corrupted.

// File: rtl/pcbf_pkg.sv
package pcbf_pkg;
    localparam int FRAME_LEN = 20;
    localparam int PAYLOAD_W = 14;
    localparam int CRC_W     = 4;
    localparam int IDX_W     = $clog2(FRAME_LEN);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_DONE = 2'd2
    } pcbf_state_e;
endpackage

// File: rtl/pcbf_crc4.sv
module pcbf_crc4 #(
    parameter int DATA_W = 14
) (
    input  logic [DATA_W-1:0] data,
    output logic [3:0]        crc
);
    always_comb begin
        logic [3:0] c;
        logic       fb;
        c = 4'b0000;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = data[i] ^ c[3];
            c  = {c[2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
        end
        crc = c;
    end
endmodule

// File: rtl/pcbf_bit_timer.sv
module pcbf_bit_timer #(
    parameter int TICKS_PER_BIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic period_end
);
    localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

    logic [CW-1:0] cnt;

    assign period_end = run && tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear || period_end)
            cnt <= '0;
        else if (run && tick)
            cnt <= cnt + 1'b1;
    end

    // R5: counter never passes the last tick of a period
    a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // R5: without a tick the count holds
    a_r5_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(cnt));
endmodule

// File: rtl/pcbf_tx.sv
module pcbf_tx #(
    parameter int TICKS_PER_BIT = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       ms_tick,
    input  logic [3:0] cutback,
    input  logic       crc_err_in,
    output logic       pwr_full,
    output logic       busy,
    output logic       done
);
    import pcbf_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    pcbf_state_e          state, state_nx;
    logic [FRAME_LEN-1:0] frame_q;
    logic [IDX_W-1:0]     bit_idx;
    logic [PAYLOAD_W-1:0] payload;
    logic [CRC_W-1:0]     crc;
    logic                 period_end;
    logic                 accept;

    assign payload = {crc_err_in, cutback, 9'b0};
    assign accept  = (state == ST_IDLE) && start;

    pcbf_crc4 #(.DATA_W(PAYLOAD_W)) u_crc (
        .data (payload),
        .crc  (crc)
    );

    pcbf_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .run        (state == ST_SEND),
        .tick       (ms_tick),
        .period_end (period_end)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_SEND;
            ST_SEND: if (period_end && bit_idx == LAST_IDX) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            frame_q <= '0;
            bit_idx <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                frame_q <= {2'b10, payload, crc};
                bit_idx <= '0;
            end else if (state == ST_SEND && period_end && bit_idx != LAST_IDX) begin
                frame_q <= {frame_q[FRAME_LEN-2:0], 1'b0};
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pwr_full = 1'b1;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SEND: begin
                busy     = 1'b1;
                pwr_full = frame_q[FRAME_LEN-1];
            end
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    // R1: full power whenever no frame bit is on the line
    a_r1_idle_full: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> pwr_full);
    // R2: accepted start raises busy next cycle
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
    // R3: bit index stays inside the frame
    a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= LAST_IDX);
    // R5: a cycle without a tick does not move the frame
    a_r5_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && !ms_tick) |=> (state == ST_SEND && $stable(pwr_full) && $stable(bit_idx)));
    // R7: start while sending leaves the frame alone
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && start && !ms_tick) |=> ($stable(frame_q) && $stable(bit_idx)));
    // R8: done is a single-cycle pulse that follows a busy cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && busy));
endmodule

// File: tb/pcbf_tx_tb.sv
module pcbf_tx_tb;
    localparam int TPB = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       ms_tick = 1'b0;
    logic [3:0] cutback = 4'd0;
    logic       crc_err_in = 1'b0;
    logic       pwr_full, busy, done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pcbf_tx #(.TICKS_PER_BIT(TPB)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ms_tick(ms_tick),
        .cutback(cutback), .crc_err_in(crc_err_in),
        .pwr_full(pwr_full), .busy(busy), .done(done)
    );

    function automatic logic [3:0] exp_crc(input logic [13:0] d);
        logic [3:0] r = 4'b0;
        for (int i = 13; i >= 0; i--) begin
            logic m;
            m = r[3];
            r = {r[2:0], 1'b0};
            if (m ^ d[i]) r = r ^ 4'h3;
        end
        return r;
    endfunction

    function automatic logic [19:0] exp_frame(input logic [3:0] cb, input logic ce);
        logic [13:0] p = {ce, cb, 9'b0};
        return {2'b10, p, exp_crc(p)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic one_tick(input int gap);
        repeat (gap) @(negedge clk);
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
    endtask

    task automatic run_frame(input logic [3:0] cb, input logic ce, input bit disturb);
        logic [19:0] f;
        f = exp_frame(cb, ce);
        @(negedge clk);
        cutback = cb; crc_err_in = ce; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", busy, 1);
        for (int b = 0; b < 20; b++) begin
            chk($sformatf("R3 R4 R6 bit %0d", b), pwr_full, f[19-b]);
            for (int t = 0; t < TPB; t++) begin
                if (disturb && b == 5 && t == 3) begin
                    start = 1'b1; cutback = ~cb; crc_err_in = ~ce;
                    @(negedge clk);
                    start = 1'b0;
                    chk("R7 start while busy ignored", pwr_full, f[19-b]);
                    chk("R7 busy held", busy, 1);
                end
                if (t == TPB - 1)
                    chk($sformatf("R5 bit %0d held until last tick", b), pwr_full, f[19-b]);
                one_tick($urandom_range(0, 2));
            end
        end
        chk("R8 done pulse", done, 1);
        chk("R8 busy during done", busy, 1);
        @(negedge clk);
        chk("R8 done single", done, 0);
        chk("R8 busy low", busy, 0);
        chk("R1 idle full power", pwr_full, 1);
        cutback = 4'd0; crc_err_in = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset pwr_full", pwr_full, 1);
        rst_n = 1'b1;
        // R5: ticks while idle do nothing
        for (int i = 0; i < 5; i++) one_tick(1);
        chk("R5 idle ticks no effect busy", busy, 0);
        chk("R5 idle ticks no effect pwr", pwr_full, 1);
        // R3 R6 directed corners
        run_frame(4'd0, 1'b0, 0);
        run_frame(4'd15, 1'b1, 0);
        run_frame(4'd15, 1'b0, 0);
        // R7 R9 disturbed frame
        run_frame(4'd7, 1'b1, 1);
        for (int k = 0; k < 4; k++)
            run_frame(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), k[0]);
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule